// File: doc/BRIEF.md
# Vertical Scaler Phase and Line-Step Controller

This block steers the vertical path of a video scaler. It keeps one phase accumulator for luma and one for chroma. Each accumulator runs across a whole field and is not cleared between output lines. For every output line it requests, the filter stage receives two values per component: how many new input lines to pull from the line store, and a 6-bit interpolation phase between the two input lines it is working on. The scale is given as an increment in units of 1/1024 of an input line per output line. A value of 1024 is unity scale, smaller values enlarge the picture and larger values shrink it.

At each field start, every component takes a start offset from one of its four offset slots. The slot is chosen by the incoming field identifier and a task toggle bit. Setting different offsets per slot lets a single scaler convert between interlaced and progressive timing while keeping the sampling phase correct. The increment can be written directly, or computed by a built-in serial divider from a pair of line counts. The divider result is saturated to the 16-bit range.

Top module: `vscale_phase_ctrl`

## Requirements
- R1: After reset, `line_valid` is 0, both increments read as 1024 and all offset slots hold 0. Output lines requested before any field start behave as a field with offset 0 at unity scale.
- R2: A `line_req` pulse that does not coincide with `field_start` produces `line_valid` high in the next cycle. In that same cycle the advance and phase of both components are valid.
- R3: For the first output line of a field, with a selected 8-bit offset O (0x20 is one line), the advance is O[7:5] and the phase is 2·O[4:0].
- R4: Output line k of a field has position P(k) = 32·O + k·I in 1/1024-line units, where I is the increment. The advance is ⌊P(k)/1024⌋ − ⌊P(k−1)/1024⌋, with P(−1) taken as 0. The phase is ⌊(P(k) mod 1024)/16⌋.
- R5: The offset slot is chosen by {field_id, task_toggle}. Slot 0 is field 0 with toggle 0, slot 1 is field 0 with toggle 1, slot 2 is field 1 with toggle 0, and slot 3 is field 1 with toggle 1.
- R6: Luma and chroma keep separate increments and offsets. When both are programmed the same, their outputs are the same on every line.
- R7: The increment and the offset are captured at field start. Register writes during a field take effect only from the next field start.
- R8: When `field_start` and `line_req` are high in the same cycle, the field start is taken and the line request is dropped: no `line_valid` follows.
- R9: Register port: `cfg_addr` 0–3 write offset slots 0–3 from `cfg_wdata[7:0]`, and 4 writes the increment from `cfg_wdata[15:0]`, all for the component chosen by `cfg_comp` (0 luma, 1 chroma). Addresses 5–7 change nothing.
- R10: A `calc_go` pulse while idle loads ⌊1024·lines_in/lines_out⌋ into the increment of the component given by `calc_comp`. `calc_busy` stays high for exactly 21 cycles. A `calc_go` while busy is ignored.
- R11: A computed increment above 65535 is stored as 65535. This includes a line-out count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_comp | input | 1 | Component of write: 0 luma, 1 chroma |
| cfg_addr | input | 3 | Register select (0–3 offset slot, 4 increment) |
| cfg_wdata | input | 16 | Write data |
| calc_go | input | 1 | Start increment computation |
| calc_comp | input | 1 | Component receiving the computed increment |
| calc_lines_in | input | 11 | Input line count for computation |
| calc_lines_out | input | 11 | Output line count for computation |
| calc_busy | output | 1 | Computation in progress |
| field_start | input | 1 | Field start strobe |
| field_id | input | 1 | Field identifier, sampled with field_start |
| task_toggle | input | 1 | Task toggle bit, sampled with field_start |
| line_req | input | 1 | Output line request strobe |
| line_valid | output | 1 | Advance and phase outputs valid |
| y_advance | output | 7 | Luma input lines to advance |
| y_phase | output | 6 | Luma interpolation phase |
| c_advance | output | 7 | Chroma input lines to advance |
| c_phase | output | 6 | Chroma interpolation phase |

## Verification
The assertions assume four things about the inputs. `field_id` and `task_toggle` matter only in a `field_start` cycle. Divider operands matter only in the accepted `calc_go` cycle. A direct increment write never lands on the cycle the divider finishes. The offset slot select changes only at field boundaries. The stimulus issues register writes only between divider runs and holds the field inputs steady around each start pulse. It then sweeps increments from 1 to 65535 against all four slots, with offsets at the fraction and integer edges, and models every line position as a wide integer.

// File: rtl/vsp_pkg.sv
package vsp_pkg;

   localparam int unsigned NCOMP = 2;   // luma, chroma
   localparam int unsigned NSLOT = 4;   // offset slots per component
   localparam logic [2:0] CA_INCR = 3'd4;

   // Width of the accumulator sum: larger of increment and scaled offset, plus carry.
   function automatic int unsigned sum_width(input int unsigned inc_w, input int unsigned ofs_w,
                                             input int unsigned ofs_frac, input int unsigned frac_w);
      int unsigned ofs_sc;
      ofs_sc = ofs_w - ofs_frac + frac_w;
      return ((inc_w > ofs_sc) ? inc_w : ofs_sc) + 1;
   endfunction

   function automatic int unsigned adv_width(input int unsigned inc_w, input int unsigned ofs_w,
                                             input int unsigned ofs_frac, input int unsigned frac_w);
      return sum_width(inc_w, ofs_w, ofs_frac, frac_w) - frac_w;
   endfunction

endpackage

// File: rtl/vsp_cfg_regs.sv
module vsp_cfg_regs
   import vsp_pkg::*;
#(
   parameter int unsigned INC_W  = 16,
   parameter int unsigned OFS_W  = 8,
   parameter int unsigned FRAC_W = 10,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              calc_wr,
   input  logic [INC_W-1:0]  calc_val,
   input  logic [1:0]        rd_sel,
   output logic [INC_W-1:0]  incr,
   output logic [OFS_W-1:0]  ofs_sel
);

   localparam logic [INC_W-1:0] UNITY = INC_W'(1) << FRAC_W;

   if (DATA_W < INC_W) begin : g_chk_inc
      $error("vsp_cfg_regs: DATA_W narrower than increment");
   end
   if (DATA_W < OFS_W) begin : g_chk_ofs
      $error("vsp_cfg_regs: DATA_W narrower than offset");
   end

   logic [NSLOT-1:0] slot_we;
   logic [OFS_W-1:0] ofs_q [NSLOT];
   logic             incr_we;

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      assign slot_we[g] = wr_en && (wr_addr == 3'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          ofs_q[g] <= '0;
         else if (slot_we[g]) ofs_q[g] <= wr_data[OFS_W-1:0];
      end
   end

   assign incr_we = wr_en && (wr_addr == CA_INCR);

   // Direct write wins over a divider completion in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       incr <= UNITY;
      else if (incr_we) incr <= wr_data[INC_W-1:0];
      else if (calc_wr) incr <= calc_val;
   end

   assign ofs_sel = ofs_q[rd_sel];

   // R9: unmapped addresses and idle cycles leave the increment untouched
   p_incr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!incr_we && !calc_wr) |=> $stable(incr));

   // R9: with no slot write and a steady select, the selected offset holds
   p_ofs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_we == '0) |=> ((ofs_sel == $past(ofs_sel)) || (rd_sel != $past(rd_sel))));

endmodule

// File: rtl/vsp_ratio_div.sv
module vsp_ratio_div #(
   parameter int unsigned LW     = 11,
   parameter int unsigned FRAC_W = 10,
   parameter int unsigned INC_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [LW-1:0]    nin,
   input  logic [LW-1:0]    nout,
   output logic             busy,
   output logic             done,
   output logic [INC_W-1:0] result
);

   localparam int unsigned STEPS = LW + FRAC_W;
   localparam int unsigned CW    = $clog2(STEPS + 1);

   if (STEPS < 2) begin : g_chk_steps
      $error("vsp_ratio_div: too few quotient bits");
   end

   logic [CW-1:0]    cnt;
   logic [LW-1:0]    rem;
   logic [STEPS-1:0] dvd;
   logic [STEPS-1:0] quo;
   logic [LW-1:0]    dvs;
   logic [LW-1:0]    nin_q;

   logic [LW:0]      rem_sh;
   logic             ge;
   logic [LW-1:0]    rem_nx;
   logic [STEPS-1:0] quo_nx;
   logic             over;

   assign busy = (cnt != '0);
   assign done = (cnt == CW'(1));

   // One restoring-division step per cycle.
   always_comb begin
      rem_sh = {rem, dvd[STEPS-1]};
      ge     = (rem_sh >= {1'b0, dvs});
      rem_nx = ge ? (rem_sh[LW-1:0] - dvs) : rem_sh[LW-1:0];
      quo_nx = {quo[STEPS-2:0], ge};
   end

   if (STEPS > INC_W) begin : g_sat
      assign over   = |quo_nx[STEPS-1:INC_W];
      assign result = over ? {INC_W{1'b1}} : quo_nx[INC_W-1:0];
   end else begin : g_ext
      assign over   = 1'b0;
      assign result = INC_W'(quo_nx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         rem   <= '0;
         dvd   <= '0;
         quo   <= '0;
         dvs   <= '0;
         nin_q <= '0;
      end else if (go && !busy) begin
         cnt   <= CW'(STEPS);
         rem   <= '0;
         dvd   <= {nin, {FRAC_W{1'b0}}};
         quo   <= '0;
         dvs   <= nout;
         nin_q <= nin;
      end else if (busy) begin
         cnt <= cnt - CW'(1);
         rem <= rem_nx;
         dvd <= {dvd[STEPS-2:0], 1'b0};
         quo <= quo_nx;
      end
   end

   // R10: an unsaturated result is the exact floor quotient of the latched operands
   p_div_exact_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (dvs != '0) && !over) |->
         ((64'(result) * 64'(dvs) <= 64'({nin_q, {FRAC_W{1'b0}}})) &&
          (64'({nin_q, {FRAC_W{1'b0}}}) < 64'(result) * 64'(dvs) + 64'(dvs))));

   // R11: a zero divisor saturates
   p_div_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (dvs == '0)) |-> (&result));

   // R10: a run that starts lasts the full step count, so one cycle later it is still busy
   p_div_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !busy) |=> (busy && !done));

endmodule

// File: rtl/vsp_phase_acc.sv
module vsp_phase_acc
   import vsp_pkg::*;
#(
   parameter int unsigned INC_W    = 16,
   parameter int unsigned FRAC_W   = 10,
   parameter int unsigned OFS_W    = 8,
   parameter int unsigned OFS_FRAC = 5,
   parameter int unsigned PH_W     = 6
) (
   input  logic                                               clk,
   input  logic                                               rst_n,
   input  logic                                               fld_start,
   input  logic                                               step,
   input  logic [INC_W-1:0]                                   incr_in,
   input  logic [OFS_W-1:0]                                   ofs_in,
   output logic [adv_width(INC_W, OFS_W, OFS_FRAC, FRAC_W)-1:0] adv,
   output logic [PH_W-1:0]                                    phase
);

   localparam int unsigned SUM_W  = sum_width(INC_W, OFS_W, OFS_FRAC, FRAC_W);
   localparam int unsigned ADV_W  = SUM_W - FRAC_W;
   localparam int unsigned OSC_W  = OFS_W - OFS_FRAC + FRAC_W;
   localparam logic [INC_W-1:0] UNITY = INC_W'(1) << FRAC_W;

   if (PH_W > FRAC_W) begin : g_chk_ph
      $error("vsp_phase_acc: phase wider than fraction");
   end
   if (OFS_FRAC > FRAC_W) begin : g_chk_of
      $error("vsp_phase_acc: offset fraction wider than accumulator fraction");
   end
   if (INC_W <= FRAC_W) begin : g_chk_un
      $error("vsp_phase_acc: unity increment not representable");
   end

   logic [FRAC_W-1:0] frac_q;
   logic [SUM_W-1:0]  addend_q;
   logic [INC_W-1:0]  incr_lat;
   logic              first_q;
   logic [OSC_W-1:0]  ofs_scaled;
   logic [SUM_W-1:0]  sum;

   // Offset fraction left-aligned into the accumulator fraction.
   if (FRAC_W > OFS_FRAC) begin : g_ofs_pad
      assign ofs_scaled = {ofs_in, {(FRAC_W - OFS_FRAC){1'b0}}};
   end else begin : g_ofs_flat
      assign ofs_scaled = ofs_in;
   end

   assign sum = SUM_W'(frac_q) + addend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frac_q   <= '0;
         addend_q <= '0;
         incr_lat <= UNITY;
         first_q  <= 1'b1;
         adv      <= '0;
         phase    <= '0;
      end else if (fld_start) begin
         frac_q   <= '0;
         addend_q <= SUM_W'(ofs_scaled);
         incr_lat <= incr_in;
         first_q  <= 1'b1;
      end else if (step) begin
         frac_q   <= sum[FRAC_W-1:0];
         addend_q <= SUM_W'(incr_lat);
         first_q  <= 1'b0;
         adv      <= sum[SUM_W-1:FRAC_W];
         phase    <= sum[FRAC_W-1 -: PH_W];
      end
   end

   // R4: at unity scale every line after the first advances by exactly one
   p_unity_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !fld_start && !first_q && (incr_lat == UNITY)) |=> (adv == ADV_W'(1)));

   // R4: when zooming no line after the first skips an input line
   p_zoom_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !fld_start && !first_q && (incr_lat < UNITY)) |=> (adv <= ADV_W'(1)));

   // R7: the captured increment holds for the whole field
   p_incr_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !fld_start |=> $stable(incr_lat));

endmodule

// File: rtl/vscale_phase_ctrl.sv
module vscale_phase_ctrl
   import vsp_pkg::*;
#(
   parameter int unsigned INC_W    = 16,
   parameter int unsigned FRAC_W   = 10,
   parameter int unsigned PH_W     = 6,
   parameter int unsigned OFS_W    = 8,
   parameter int unsigned OFS_FRAC = 5,
   parameter int unsigned LW       = 11,
   parameter int unsigned DATA_W   = 16
) (
   input  logic                                                clk,
   input  logic                                                rst_n,
   input  logic                                                cfg_we,
   input  logic                                                cfg_comp,
   input  logic [2:0]                                          cfg_addr,
   input  logic [DATA_W-1:0]                                   cfg_wdata,
   input  logic                                                calc_go,
   input  logic                                                calc_comp,
   input  logic [LW-1:0]                                       calc_lines_in,
   input  logic [LW-1:0]                                       calc_lines_out,
   output logic                                                calc_busy,
   input  logic                                                field_start,
   input  logic                                                field_id,
   input  logic                                                task_toggle,
   input  logic                                                line_req,
   output logic                                                line_valid,
   output logic [adv_width(INC_W, OFS_W, OFS_FRAC, FRAC_W)-1:0] y_advance,
   output logic [PH_W-1:0]                                     y_phase,
   output logic [adv_width(INC_W, OFS_W, OFS_FRAC, FRAC_W)-1:0] c_advance,
   output logic [PH_W-1:0]                                     c_phase
);

   localparam int unsigned ADV_W = adv_width(INC_W, OFS_W, OFS_FRAC, FRAC_W);

   if (NCOMP != 2) begin : g_chk_comp
      $error("vscale_phase_ctrl: exactly two components expected");
   end

   logic             div_done;
   logic [INC_W-1:0] div_result;
   logic             calc_tgt_q;
   logic [1:0]       slot_idx;

   logic [ADV_W-1:0] adv_a [NCOMP];
   logic [PH_W-1:0]  ph_a  [NCOMP];

   assign slot_idx = {field_id, task_toggle};

   vsp_ratio_div #(
      .LW     (LW),
      .FRAC_W (FRAC_W),
      .INC_W  (INC_W)
   ) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (calc_go),
      .nin    (calc_lines_in),
      .nout   (calc_lines_out),
      .busy   (calc_busy),
      .done   (div_done),
      .result (div_result)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      calc_tgt_q <= 1'b0;
      else if (calc_go && !calc_busy)  calc_tgt_q <= calc_comp;
   end

   for (genvar c = 0; c < NCOMP; c++) begin : g_comp
      logic [INC_W-1:0] incr_c;
      logic [OFS_W-1:0] ofs_c;

      vsp_cfg_regs #(
         .INC_W  (INC_W),
         .OFS_W  (OFS_W),
         .FRAC_W (FRAC_W),
         .DATA_W (DATA_W)
      ) u_regs (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (cfg_we && (cfg_comp == 1'(c))),
         .wr_addr  (cfg_addr),
         .wr_data  (cfg_wdata),
         .calc_wr  (div_done && (calc_tgt_q == 1'(c))),
         .calc_val (div_result),
         .rd_sel   (slot_idx),
         .incr     (incr_c),
         .ofs_sel  (ofs_c)
      );

      vsp_phase_acc #(
         .INC_W    (INC_W),
         .FRAC_W   (FRAC_W),
         .OFS_W    (OFS_W),
         .OFS_FRAC (OFS_FRAC),
         .PH_W     (PH_W)
      ) u_acc (
         .clk       (clk),
         .rst_n     (rst_n),
         .fld_start (field_start),
         .step      (line_req),
         .incr_in   (incr_c),
         .ofs_in    (ofs_c),
         .adv       (adv_a[c]),
         .phase     (ph_a[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_valid <= 1'b0;
      else        line_valid <= line_req && !field_start;
   end

   assign y_advance = adv_a[0];
   assign y_phase   = ph_a[0];
   assign c_advance = adv_a[1];
   assign c_phase   = ph_a[1];

   // R2: valid only one cycle after an accepted line request
   p_valid_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      line_valid |-> $past(line_req && !field_start));

   // R8: a field start never yields a valid in the following cycle
   p_start_drops_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
      field_start |=> !line_valid);

   // R2: outputs change only when a line is delivered
   p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !line_valid |-> ($stable(y_phase) && $stable(c_phase) && $stable(y_advance) && $stable(c_advance)));

endmodule

// File: tb/vscale_phase_ctrl_tb.sv
`timescale 1ns/1ps
module vscale_phase_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_comp = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        calc_go = 1'b0, calc_comp = 1'b0;
   logic [10:0] calc_lines_in = '0, calc_lines_out = '0;
   logic        calc_busy;
   logic        field_start = 1'b0, field_id = 1'b0, task_toggle = 1'b0, line_req = 1'b0;
   logic        line_valid;
   logic [6:0]  y_advance, c_advance;
   logic [5:0]  y_phase, c_phase;

   always #5 clk = ~clk;

   vscale_phase_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_comp(cfg_comp), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .calc_go(calc_go), .calc_comp(calc_comp),
      .calc_lines_in(calc_lines_in), .calc_lines_out(calc_lines_out), .calc_busy(calc_busy),
      .field_start(field_start), .field_id(field_id), .task_toggle(task_toggle),
      .line_req(line_req), .line_valid(line_valid), .y_advance(y_advance), .y_phase(y_phase),
      .c_advance(c_advance), .c_phase(c_phase)
   );

   int errors = 0;
   int checks = 0;
   int mdl_ofs [2][4];
   int mdl_inc [2];
   longint cur_off [2];
   longint cur_inc [2];
   longint cur_k;

   task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic void exp_line(input longint off, input longint inc, input longint k,
                                    output longint adv, output longint ph);
      longint p, q;
      p = off * 32 + k * inc;
      q = (k == 0) ? 0 : off * 32 + (k - 1) * inc;
      adv = p / 1024 - q / 1024;
      ph  = (p % 1024) / 16;
   endfunction

   task automatic cfg_wr(input int comp, input int addr, input int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_comp = comp[0]; cfg_addr = addr[2:0]; cfg_wdata = data[15:0];
      @(negedge clk);
      cfg_we = 1'b0;
      if (addr < 4)       mdl_ofs[comp][addr] = data & 255;
      else if (addr == 4) mdl_inc[comp] = data & 65535;
   endtask

   task automatic take_field(input int fid, input int tog);
      for (int c = 0; c < 2; c++) begin
         cur_off[c] = mdl_ofs[c][fid * 2 + tog];
         cur_inc[c] = mdl_inc[c];
      end
      cur_k = 0;
   endtask

   task automatic new_field(input int fid, input int tog);
      @(negedge clk);
      field_start = 1'b1; field_id = fid[0]; task_toggle = tog[0];
      @(negedge clk);
      field_start = 1'b0;
      take_field(fid, tog);
   endtask

   task automatic one_line(input string req);
      longint ea, ep;
      @(negedge clk);
      line_req = 1'b1;
      @(negedge clk);
      line_req = 1'b0;
      chk(line_valid == 1'b1, "R2", "line_valid", line_valid, 1);
      exp_line(cur_off[0], cur_inc[0], cur_k, ea, ep);
      chk(y_advance == ea[6:0] && y_phase == ep[5:0], req, "luma adv*64+phase",
          y_advance * 64 + y_phase, ea * 64 + ep);
      exp_line(cur_off[1], cur_inc[1], cur_k, ea, ep);
      chk(c_advance == ea[6:0] && c_phase == ep[5:0], req, "chroma adv*64+phase",
          c_advance * 64 + c_phase, ea * 64 + ep);
      cur_k++;
   endtask

   task automatic run_calc(input int comp, input int nin, input int nout, input string req);
      int busy_n;
      longint expv;
      @(negedge clk);
      calc_go = 1'b1; calc_comp = comp[0];
      calc_lines_in = nin[10:0]; calc_lines_out = nout[10:0];
      @(negedge clk);
      calc_go = 1'b0;
      busy_n = 0;
      while (calc_busy && busy_n < 100) begin
         busy_n++;
         @(negedge clk);
      end
      chk(busy_n == 21, "R10", "busy cycles", busy_n, 21);
      expv = (nout == 0) ? 65535 : (longint'(nin) * 1024) / nout;
      if (expv > 65535) expv = 65535;
      mdl_inc[comp] = int'(expv);
   endtask

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL R2 watchdog expired: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int incs [8];
      int ofsv [5];
      incs = '{1024, 512, 1000, 1536, 3000, 65535, 1, 700};
      ofsv = '{0, 31, 32, 255, 19};
      for (int c = 0; c < 2; c++) begin
         mdl_inc[c] = 1024;
         for (int s = 0; s < 4; s++) mdl_ofs[c][s] = 0;
      end

      repeat (3) @(negedge clk);
      chk(line_valid == 1'b0, "R1", "line_valid in reset", line_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(line_valid == 1'b0, "R1", "line_valid after reset", line_valid, 0);
      // R1: lines before any field start run at unity with zero offset
      take_field(0, 0);
      for (int k = 0; k < 4; k++) one_line("R1");
      // R1: reset increments and offsets seen through a field in every slot
      for (int s = 0; s < 4; s++) begin
         new_field(s / 2, s % 2);
         for (int k = 0; k < 3; k++) one_line("R1");
      end

      // R3 R4 R5 R6: sweep increments, per-slot offsets, different luma/chroma settings
      for (int i = 0; i < 8; i++) begin
         cfg_wr(0, 4, incs[i]);
         cfg_wr(1, 4, incs[7 - i]);
         for (int s = 0; s < 4; s++) begin
            cfg_wr(0, s, ofsv[(i + s) % 5]);
            cfg_wr(1, s, ofsv[(i + s + 2) % 5]);
         end
         for (int s = 0; s < 4; s++) begin
            new_field(s / 2, s % 2);
            one_line("R3");
            for (int k = 1; k < 6; k++) one_line("R5");
         end
      end

      // R6: identical settings give identical outputs
      cfg_wr(0, 4, 1365); cfg_wr(1, 4, 1365);
      cfg_wr(0, 2, 16);   cfg_wr(1, 2, 16);
      new_field(1, 0);
      for (int k = 0; k < 6; k++) begin
         one_line("R6");
         chk(y_advance == c_advance && y_phase == c_phase, "R6", "luma vs chroma",
             y_advance * 64 + y_phase, c_advance * 64 + c_phase);
      end

      // R7: writes during a field apply only from the next field
      cfg_wr(0, 4, 800); cfg_wr(1, 4, 900);
      cfg_wr(0, 1, 7);   cfg_wr(1, 1, 40);
      new_field(0, 1);
      one_line("R7"); one_line("R7");
      cfg_wr(0, 4, 2500); cfg_wr(1, 4, 333);
      cfg_wr(0, 1, 200);  cfg_wr(1, 1, 1);
      for (int k = 0; k < 4; k++) one_line("R7");
      new_field(0, 1);
      for (int k = 0; k < 4; k++) one_line("R7");

      // R8: field start and line request together
      @(negedge clk);
      field_start = 1'b1; line_req = 1'b1; field_id = 1'b1; task_toggle = 1'b1;
      @(negedge clk);
      field_start = 1'b0; line_req = 1'b0;
      chk(line_valid == 1'b0, "R8", "line_valid on start+req", line_valid, 0);
      take_field(1, 1);
      for (int k = 0; k < 4; k++) one_line("R8");

      // R9: unmapped addresses change nothing
      cfg_wr(0, 5, 16'h1234); cfg_wr(1, 6, 16'hFFFF); cfg_wr(0, 7, 16'h00AA);
      for (int s = 0; s < 4; s++) begin
         new_field(s / 2, s % 2);
         for (int k = 0; k < 3; k++) one_line("R9");
      end

      // R10: computed increments
      run_calc(0, 480, 240, "R10"); run_calc(1, 240, 480, "R10");
      new_field(0, 0);
      for (int k = 0; k < 5; k++) one_line("R10");
      run_calc(0, 576, 480, "R10"); run_calc(1, 7, 3, "R10");
      new_field(1, 0);
      for (int k = 0; k < 5; k++) one_line("R10");
      run_calc(1, 63, 1, "R10");
      new_field(0, 1);
      for (int k = 0; k < 4; k++) one_line("R10");

      // R10: go while busy is ignored
      @(negedge clk);
      calc_go = 1'b1; calc_comp = 1'b0; calc_lines_in = 11'd300; calc_lines_out = 11'd200;
      @(negedge clk);
      calc_comp = 1'b1; calc_lines_in = 11'd5; calc_lines_out = 11'd9;
      @(negedge clk);
      calc_go = 1'b0;
      repeat (25) @(negedge clk);
      chk(calc_busy == 1'b0, "R10", "busy after run", calc_busy, 0);
      mdl_inc[0] = (300 * 1024) / 200;
      new_field(0, 0);
      for (int k = 0; k < 4; k++) one_line("R10");

      // R11: saturation
      run_calc(0, 64, 1, "R11");
      run_calc(1, 100, 0, "R11");
      new_field(1, 1);
      for (int k = 0; k < 4; k++) one_line("R11");
      run_calc(0, 2047, 1, "R11");
      run_calc(1, 0, 0, "R11");
      new_field(0, 0);
      for (int k = 0; k < 4; k++) one_line("R11");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule